// File: doc/BRIEF.md
# Four-CPU Interrupt Routing Register Block

This block gathers up to 64 device interrupt request lines and routes them to four processors. A software-visible register file holds one 64-bit enable mask for each CPU. The masked pending vector of each CPU drives that CPU's device interrupt line. The block also keeps two small latches, each with one bit per CPU. One holds pending inter-processor interrupts (IPIs) and the other holds pending interval-timer interrupts. Software raises and clears IPIs and clears timer interrupts through register writes. A one-cycle tick input marks a timer interrupt as pending on all four CPUs.

Software reaches the block with 64-bit accesses. Each access is a single-cycle request carrying a byte offset, an access size, write data and the issuing CPU's identifier. The registered response comes one cycle later. It carries read data and an error flag. Accesses that are too narrow, unknown or not permitted get an error response and leave all state as it was.

Top module: `irqc_top`

## Requirements
- R1: The register index is the byte offset shifted right by 6. The map is: 0 status, 1 miscellaneous, 2–5 address-array, 6–9 mask of CPU 0–3, 10–13 pending of CPU 0–3, 14 raw request, 15 IPI-pending, 16 timer-pending, 17 IPI-post. Every request gets rsp_valid exactly one cycle later.
- R2: An access whose req_size is not 3 (3 means 64 bits, while 0, 1 and 2 are 8, 16 and 32 bits) returns rsp_err=1 with zero data and changes no state.
- R3: A mask register reads back the value last written to it, and its reset value is zero. Pending register n reads as mask n AND the raw register. The raw register reads the dev_req value that was sampled at the previous clock edge.
- R4: dev_irq[n] is the OR of CPU n's masked pending vector. It follows a dev_req change one cycle later, and it follows a mask write at the same edge that accepts the write.
- R5: In a write to the miscellaneous register, bits 15:12 post an IPI to each CPU named and bits 11:8 clear that CPU's IPI. Bits 7:4 clear the timer interrupt of each CPU named. If the same write posts and clears an IPI for one CPU, the clear wins.
- R6: A miscellaneous write with only bit 28 set is accepted with no error and no state change. A miscellaneous write with none of bits 28, 15:4 set returns rsp_err=1.
- R7: A write to the IPI-pending register clears the IPIs named in wdata[3:0]. A write to the timer-pending register clears the named timer bits. A write to the IPI-post register raises the named IPIs.
- R8: Reads of the status register and of the address-array registers return zero. Reads of the IPI-pending or timer-pending register return the 4-bit vector in bits 3:0. Writes to the address-array registers are accepted and have no effect.
- R9: A miscellaneous read returns the pending IPIs in bits 11:8, the pending timer bits in bits 7:4 and req_cpu in bits 1:0. All other bits read zero.
- R10: tick sets all four timer-pending bits at the next edge. A timer clear in the same cycle as tick loses.
- R11: Each of the following gives rsp_err=1, zero read data and no state change: an index above 17, a write to the status, pending or raw register, and a read of IPI-post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset from block base |
| req_size | input | 2 | Access size code, 3 = 64-bit |
| req_cpu | input | 2 | Identifier of the issuing CPU |
| req_wdata | input | 64 | Write data |
| dev_req | input | 64 | Device interrupt request lines |
| tick | input | 1 | Interval-timer tick pulse |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Error response flag |
| rsp_rdata | output | 64 | Read data |
| dev_irq | output | 4 | Per-CPU device interrupt |
| ipi_irq | output | 4 | Per-CPU inter-processor interrupt |
| tmr_irq | output | 4 | Per-CPU timer interrupt |

## Verification
The bench raises a request just after a falling edge. It then reads the response, the latches and the interrupt lines at the next falling edge, which is half a cycle after the one rising edge that registers them. The one exception is a dev_req change, which first reaches the raw register at that edge. dev_irq reflects it at the same falling edge, so the bench does not sample dev_irq earlier. The tick-against-clear race is driven inside a single request cycle so that both land on the same edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NCPU   = 4;
  localparam int DW     = 64;
  localparam int SELW   = $clog2(NCPU);
  localparam int IDXW   = 6;
  localparam int IDX_STAT = 0;
  localparam int IDX_MISC = 1;
  localparam int IDX_AAR  = 2;
  localparam int IDX_MASK = IDX_AAR + NCPU;
  localparam int IDX_PEND = IDX_MASK + NCPU;
  localparam int IDX_RAW  = IDX_PEND + NCPU;
  localparam int IDX_IPIR = IDX_RAW + 1;
  localparam int IDX_TMRR = IDX_IPIR + 1;
  localparam int IDX_IPIQ = IDX_TMRR + 1;
  localparam int MISC_POST = 12;
  localparam int MISC_CIPI = 8;
  localparam int MISC_CTMR = 4;
  localparam int MISC_NXM  = 28;
  localparam logic [1:0] SZ_64 = 2'd3;

  typedef enum logic [3:0] {
    K_STAT, K_MISC, K_AAR, K_MASK, K_PEND, K_RAW,
    K_IPIR, K_TMRR, K_IPIQ, K_NONE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [SELW-1:0]  sel;
    logic             err;
  } dec_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output dec_t              dec
);
  logic [IDXW-1:0] idx;
  logic            misc_any;

  assign idx = IDXW'(addr >> 6);
  assign misc_any = (|wdata[MISC_POST +: NCPU]) | (|wdata[MISC_CIPI +: NCPU]) |
                    (|wdata[MISC_CTMR +: NCPU]) | wdata[MISC_NXM];

  always_comb begin
    dec.sel  = '0;
    dec.kind = K_NONE;
    if (idx == IDXW'(IDX_STAT))      dec.kind = K_STAT;
    else if (idx == IDXW'(IDX_MISC)) dec.kind = K_MISC;
    else if (idx >= IDXW'(IDX_AAR) && idx < IDXW'(IDX_MASK)) dec.kind = K_AAR;
    else if (idx >= IDXW'(IDX_MASK) && idx < IDXW'(IDX_PEND)) begin
      dec.kind = K_MASK;
      dec.sel  = SELW'(idx - IDXW'(IDX_MASK));
    end else if (idx >= IDXW'(IDX_PEND) && idx < IDXW'(IDX_RAW)) begin
      dec.kind = K_PEND;
      dec.sel  = SELW'(idx - IDXW'(IDX_PEND));
    end else if (idx == IDXW'(IDX_RAW))  dec.kind = K_RAW;
    else if (idx == IDXW'(IDX_IPIR)) dec.kind = K_IPIR;
    else if (idx == IDXW'(IDX_TMRR)) dec.kind = K_TMRR;
    else if (idx == IDXW'(IDX_IPIQ)) dec.kind = K_IPIQ;

    dec.err = (size != SZ_64) || (dec.kind == K_NONE);
    if (we && (dec.kind == K_STAT || dec.kind == K_PEND || dec.kind == K_RAW))
      dec.err = 1'b1;
    if (!we && dec.kind == K_IPIQ) dec.err = 1'b1;
    if (we && dec.kind == K_MISC && !misc_any) dec.err = 1'b1;
  end
endmodule

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank
  import irqc_pkg::*;
#(
  parameter int N_DEV = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [SELW-1:0]            wr_sel,
  input  logic [N_DEV-1:0]           wr_data,
  input  logic [N_DEV-1:0]           dev_req,
  output logic [N_DEV-1:0]           raw,
  output logic [NCPU-1:0][N_DEV-1:0] mask,
  output logic [NCPU-1:0][N_DEV-1:0] pend,
  output logic [NCPU-1:0]            dev_irq
);
  always_ff @(posedge clk) begin
    if (rst) raw <= '0;
    else     raw <= dev_req;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst)                                  mask[c] <= '0;
      else if (wr_en && wr_sel == SELW'(c))     mask[c] <= wr_data;
    end
    assign pend[c]    = mask[c] & raw;
    assign dev_irq[c] = |pend[c];
  end
endmodule

// File: rtl/irqc_pend_latch.sv
module irqc_pend_latch #(
  parameter int N        = 4,
  parameter bit SET_WINS = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_n;

  if (SET_WINS) begin : g_set_wins
    assign q_n = (q & ~clr) | set;
  end else begin : g_clr_wins
    assign q_n = (q | set) & ~clr;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_n;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_DEV  = 64,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [SELW-1:0]   req_cpu,
  input  logic [DW-1:0]     req_wdata,
  input  logic [N_DEV-1:0]  dev_req,
  input  logic              tick,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata,
  output logic [NCPU-1:0]   dev_irq,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq
);
  dec_t                      dec;
  logic                      acc_ok, wr_ok;
  logic [N_DEV-1:0]          raw;
  logic [NCPU-1:0][N_DEV-1:0] mask, pend;
  logic [NCPU-1:0]           ipi_set, ipi_clr, tmr_set, tmr_clr;
  logic [DW-1:0]             rd_mux;

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .size(req_size), .we(req_we), .wdata(req_wdata), .dec(dec)
  );

  assign acc_ok = req_valid && !dec.err;
  assign wr_ok  = acc_ok && req_we;

  irqc_mask_bank #(.N_DEV(N_DEV)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_ok && dec.kind == K_MASK), .wr_sel(dec.sel),
    .wr_data(req_wdata[N_DEV-1:0]), .dev_req(dev_req),
    .raw(raw), .mask(mask), .pend(pend), .dev_irq(dev_irq)
  );

  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    if (wr_ok && dec.kind == K_MISC) begin
      ipi_set = req_wdata[MISC_POST +: NCPU];
      ipi_clr = req_wdata[MISC_CIPI +: NCPU];
      tmr_clr = req_wdata[MISC_CTMR +: NCPU];
    end
    if (wr_ok && dec.kind == K_IPIQ) ipi_set = ipi_set | req_wdata[NCPU-1:0];
    if (wr_ok && dec.kind == K_IPIR) ipi_clr = ipi_clr | req_wdata[NCPU-1:0];
    if (wr_ok && dec.kind == K_TMRR) tmr_clr = tmr_clr | req_wdata[NCPU-1:0];
  end
  assign tmr_set = {NCPU{tick}};

  irqc_pend_latch #(.N(NCPU), .SET_WINS(1'b0)) u_ipi (
    .clk(clk), .rst(rst), .set(ipi_set), .clr(ipi_clr), .q(ipi_irq)
  );
  irqc_pend_latch #(.N(NCPU), .SET_WINS(1'b1)) u_tmr (
    .clk(clk), .rst(rst), .set(tmr_set), .clr(tmr_clr), .q(tmr_irq)
  );

  always_comb begin
    rd_mux = '0;
    case (dec.kind)
      K_MISC: begin
        rd_mux[MISC_CIPI +: NCPU] = ipi_irq;
        rd_mux[MISC_CTMR +: NCPU] = tmr_irq;
        rd_mux[SELW-1:0]          = req_cpu;
      end
      K_MASK: rd_mux[N_DEV-1:0] = mask[dec.sel];
      K_PEND: rd_mux[N_DEV-1:0] = pend[dec.sel];
      K_RAW:  rd_mux[N_DEV-1:0] = raw;
      K_IPIR: rd_mux[NCPU-1:0]  = ipi_irq;
      K_TMRR: rd_mux[NCPU-1:0]  = tmr_irq;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && dec.err;
      rsp_rdata <= (acc_ok && !req_we) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [DW-1:0]     req_wdata,
  input logic              tick,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DW-1:0]     rsp_rdata,
  input logic [NCPU-1:0]   ipi_irq,
  input logic [NCPU-1:0]   tmr_irq
);
  logic [ADDR_W-1:0] idx;
  assign idx = req_addr >> 6;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R1
  AST_NARROW_ERR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size != SZ_64) |=> (rsp_err && rsp_rdata == '0)); // R2
  AST_NARROW_KEEPS_IPI: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size != SZ_64) |=> (ipi_irq == $past(ipi_irq))); // R2
  AST_MISC_POST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && req_size == SZ_64 && idx == ADDR_W'(IDX_MISC) &&
     req_wdata[MISC_POST] && !req_wdata[MISC_CIPI]) |=> ipi_irq[0]); // R5
  AST_TICK_SETS_ALL: assert property (@(posedge clk) disable iff (rst)
    tick |=> (tmr_irq == '1)); // R10
  AST_UNKNOWN_ERR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && idx > ADDR_W'(IDX_IPIQ)) |=> rsp_err); // R11
endmodule

bind irqc_top irqc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
  .tick(tick), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_we, tick;
  logic [11:0] req_addr;
  logic [1:0]  req_size, req_cpu;
  logic [63:0] req_wdata, dev_req, rsp_rdata;
  logic        rsp_valid, rsp_err;
  logic [3:0]  dev_irq, ipi_irq, tmr_irq;
  int errors = 0;
  int checks = 0;
  logic [63:0] rd;
  logic        er;

  always #5 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_cpu(req_cpu),
    .req_wdata(req_wdata), .dev_req(dev_req), .tick(tick),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dev_irq(dev_irq), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input int idx, input logic [1:0] sz,
                     input logic [63:0] wd, input logic [1:0] cpu = 2'd0);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = 12'(idx * 64);
    req_size = sz; req_wdata = wd; req_cpu = cpu;
    @(negedge clk);
    req_valid = 1'b0; tick = 1'b0;
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd1);
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic t_reset;
    chk("R3 reset ipi", 64'(ipi_irq), 0);
    chk("R3 reset tmr", 64'(tmr_irq), 0);
    chk("R4 reset dev_irq", 64'(dev_irq), 0);
    acc(0, 6, 3, 0); chk("R3 mask reset", rd, 0);
  endtask

  task automatic t_mask_dev;
    acc(1, 6, 3, 64'h00F0); chk("R3 mask write err", 64'(er), 0);
    acc(1, 7, 3, 64'h8000_0000_0000_0000);
    acc(0, 6, 3, 0); chk("R3 mask0 readback", rd, 64'h00F0);
    acc(0, 7, 3, 0); chk("R3 mask1 readback", rd, 64'h8000_0000_0000_0000);
    @(negedge clk); dev_req = 64'h8000_0000_0000_0010;
    @(negedge clk); chk("R4 dev_irq after request", 64'(dev_irq), 64'h3);
    acc(0, 10, 3, 0); chk("R3 pending0", rd, 64'h10);
    acc(0, 14, 3, 0); chk("R3 raw", rd, 64'h8000_0000_0000_0010);
    acc(1, 6, 3, 64'h0F); chk("R4 mask write drops irq", 64'(dev_irq), 64'h2);
    dev_req = 0;
    @(negedge clk); chk("R4 dev_irq after drop", 64'(dev_irq), 0);
  endtask

  task automatic t_misc;
    acc(1, 1, 3, 64'hF000); chk("R5 post all", 64'(ipi_irq), 64'hF);
    acc(1, 1, 3, 64'h0100); chk("R5 clear cpu0", 64'(ipi_irq), 64'hE);
    acc(1, 1, 3, 64'h2200); chk("R5 clear wins over post", 64'(ipi_irq), 64'hC);
    acc(1, 1, 3, 64'h1000_0000); chk("R6 nxm only no err", 64'(er), 0);
    chk("R6 nxm only no change", 64'(ipi_irq), 64'hC);
    acc(1, 1, 3, 64'h1); chk("R6 no field err", 64'(er), 1);
    acc(0, 1, 3, 0, 2'd2); chk("R9 misc read", rd, 64'hC02);
  endtask

  task automatic t_tick;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; chk("R10 tick sets all", 64'(tmr_irq), 64'hF);
    acc(1, 1, 3, 64'h0030); chk("R5 timer clear", 64'(tmr_irq), 64'hC);
    acc(1, 16, 3, 64'h4); chk("R7 timer reg clear", 64'(tmr_irq), 64'h8);
    acc(0, 16, 3, 0); chk("R8 timer reg read", rd, 64'h8);
    @(negedge clk); tick = 1'b1;
    acc(1, 16, 3, 64'hF); chk("R10 tick beats clear", 64'(tmr_irq), 64'hF);
  endtask

  task automatic t_regs;
    acc(1, 17, 3, 64'h3); chk("R7 ipi post reg", 64'(ipi_irq), 64'hF);
    acc(1, 15, 3, 64'h5); chk("R7 ipi clear reg", 64'(ipi_irq), 64'hA);
    acc(0, 15, 3, 0); chk("R8 ipi reg read", rd, 64'hA);
    acc(0, 0, 3, 0); chk("R8 status zero", rd, 0);
    acc(1, 3, 3, 64'hDEAD); chk("R8 aar write accepted", 64'(er), 0);
    acc(0, 3, 3, 0); chk("R8 aar read zero", rd, 0);
  endtask

  task automatic t_errors;
    acc(1, 6, 2, 64'hFFFF); chk("R2 narrow err", 64'(er), 1);
    acc(0, 6, 3, 0); chk("R2 narrow no change", rd, 64'h0F);
    acc(0, 6, 0, 0); chk("R2 narrow read zero", rd, 0);
    acc(1, 1, 1, 64'hF00); chk("R2 narrow misc no change", 64'(ipi_irq), 64'hA);
    acc(0, 40, 3, 0); chk("R11 unknown err", 64'(er), 1);
    chk("R11 unknown zero", rd, 0);
    acc(1, 10, 3, 64'hFF); chk("R11 write pending err", 64'(er), 1);
    acc(0, 17, 3, 0); chk("R11 read post err", 64'(er), 1);
    acc(1, 0, 3, 64'h1); chk("R11 write status err", 64'(er), 1);
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_we = 0; req_addr = 0; req_size = 3;
    req_cpu = 0; req_wdata = 0; dev_req = 0; tick = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask_dev();
    t_misc();
    t_tick();
    t_regs();
    t_errors();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule